// File: doc/BRIEF.md
# Registered 64-bit Shift and Rotate Unit with Carry and Overflow Flags

This unit takes a 64-bit operand, an 8-bit count and a 3-bit operation code. It produces the shifted or rotated operand together with a carry flag and an overflow flag. The flags match what a loop of single-bit steps would leave behind. The carry is the last bit that left the operand, or the last bit that wrapped around. The overflow reports a sign change, and only for a move of exactly one position.

A flag-valid output tells the surrounding datapath whether the flags carry news. When the effective count is zero, or the operation code is unused, the result equals the operand and flag-valid is low. The caller then keeps its previous carry and overflow. The datapath is combinational and ends in one output register. Results appear one clock after the inputs are presented, and a synchronous active-high reset clears them.

Top module: `shrot_unit`

## Requirements
- R1: Operation codes 3'b000 and 3'b001 both shift the operand left by the effective count and fill the vacated low bits with zeros; the two codes give identical outputs.
- R2: Operation code 3'b010 shifts right and fills the vacated high bits with zeros.
- R3: Operation code 3'b011 shifts right and fills the vacated high bits with copies of operand bit 63.
- R4: Operation code 3'b100 rotates left and 3'b101 rotates right; bits leaving one end enter at the other, so no bit is lost.
- R5: For a shift with a nonzero effective count, the carry output equals the last bit moved out of the operand. For a left shift by n this is operand bit 64-n; for a right shift by n it is operand bit n-1.
- R6: For a rotate with a nonzero effective count, the carry output equals the last bit carried around. This is result bit 0 for a left rotate and result bit 63 for a right rotate.
- R7: The effective count is count_i[5:0]; bits 7:6 of count_i have no effect on any output.
- R8: An effective count of zero gives result equal to the operand, with flags_valid_o, carry_o and overflow_o all 0.
- R9: For an effective count of one on a valid operation, overflow_o equals result bit 63 XOR operand bit 63.
- R10: For an effective count of two or more, overflow_o is 0; its value is undefined to the caller and is driven low.
- R11: Operation codes 3'b110 and 3'b111 are unused: the result equals the operand and flags_valid_o, carry_o and overflow_o are 0.
- R12: All outputs are registered. They reflect the inputs present at the previous rising clock edge, and they are all zero in the cycle after a clock edge with rst high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| operand_i | input | 64 | Value to shift or rotate |
| count_i | input | 8 | Move amount; only the low 6 bits are used |
| op_i | input | 3 | Operation code |
| result_o | output | 64 | Registered result |
| carry_o | output | 1 | Last bit moved out or wrapped |
| overflow_o | output | 1 | Sign change, meaningful only for a count of one |
| flags_valid_o | output | 1 | High when carry and overflow should update |

## Verification
There is no internal state apart from the output register. A wrong stage select in the barrel network or a wrong carry index therefore shows on result_o or carry_o in the very next cycle after the offending input. Single-bit stage faults appear only for counts that set that amount bit. For this reason the stimulus covers every count from 0 to 63, plus counts with the upper bits set, for each operation. Fill faults on arithmetic right shifts show only with a negative operand, and overflow faults only at a count of one. Both get directed vectors.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_SHL = 3'b000,
    OP_SAL = 3'b001,
    OP_SHR = 3'b010,
    OP_SAR = 3'b011,
    OP_ROL = 3'b100,
    OP_ROR = 3'b101,
    OP_RS6 = 3'b110,
    OP_RS7 = 3'b111
  } shrot_op_e;

  typedef struct packed {
    logic dir_left;
    logic rotate;
    logic arith;
    logic legal;
  } shrot_ctl_t;
endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
  import shrot_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SH_W  = 6
) (
  input  logic [OPW-1:0]   op,
  input  logic [CNT_W-1:0] count,
  output shrot_ctl_t       ctl,
  output logic [SH_W-1:0]  amt,
  output logic             active
);
  shrot_op_e op_e;

  always_comb begin
    op_e = shrot_op_e'(op);
    ctl  = '0;
    unique case (op_e)
      OP_SHL, OP_SAL: begin ctl.dir_left = 1'b1; ctl.legal = 1'b1; end
      OP_SHR:         begin ctl.legal = 1'b1; end
      OP_SAR:         begin ctl.arith = 1'b1; ctl.legal = 1'b1; end
      OP_ROL:         begin ctl.dir_left = 1'b1; ctl.rotate = 1'b1; ctl.legal = 1'b1; end
      OP_ROR:         begin ctl.rotate = 1'b1; ctl.legal = 1'b1; end
      default:        ctl = '0;
    endcase
  end

  // upper count bits are dropped here; an unused code forces a zero amount
  assign amt    = ctl.legal ? count[SH_W-1:0] : '0;
  assign active = (amt != '0);
endmodule

// File: rtl/shrot_barrel.sv
module shrot_barrel #(
  parameter int W    = 64,
  parameter int SH_W = 6
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  input  logic            dir_left,
  input  logic            rotate,
  input  logic            arith,
  output logic [W-1:0]    dout
);
  logic [SH_W:0][W-1:0] stage;
  logic                 fill;

  assign fill     = arith & din[W-1];
  assign stage[0] = din;

  generate
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
      localparam int S = 1 << k;
      logic [W-1:0] lv, rv;
      assign lv = {stage[k][W-1-S:0], rotate ? stage[k][W-1:W-S] : {S{1'b0}}};
      assign rv = {rotate ? stage[k][S-1:0] : {S{fill}}, stage[k][W-1:S]};
      assign stage[k+1] = amt[k] ? (dir_left ? lv : rv) : stage[k];
    end
  endgenerate

  assign dout = stage[SH_W];
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags #(
  parameter int W    = 64,
  parameter int SH_W = 6
) (
  input  logic [W-1:0]    din,
  input  logic [W-1:0]    dout,
  input  logic [SH_W-1:0] amt,
  input  logic            dir_left,
  input  logic            rotate,
  input  logic            active,
  output logic            carry,
  output logic            overflow,
  output logic            valid
);
  localparam logic [SH_W:0] W_EXT = (SH_W+1)'(W);

  logic [SH_W:0]   left_ix_w;
  logic [SH_W-1:0] left_ix, right_ix;
  logic            raw_cf;

  assign left_ix_w = W_EXT - {1'b0, amt};
  assign left_ix   = left_ix_w[SH_W-1:0];
  assign right_ix  = amt - 1'b1;

  always_comb begin
    if (rotate)        raw_cf = dir_left ? dout[0] : dout[W-1];
    else if (dir_left) raw_cf = din[left_ix];
    else               raw_cf = din[right_ix];
  end

  assign valid    = active;
  assign carry    = active & raw_cf;
  assign overflow = active & (amt == SH_W'(1)) & (dout[W-1] ^ din[W-1]);
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int W     = 64,
  parameter int CNT_W = 8,
  localparam int SH_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     operand_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [2:0]       op_i,
  output logic [W-1:0]     result_o,
  output logic             carry_o,
  output logic             overflow_o,
  output logic             flags_valid_o
);
  shrot_ctl_t      ctl;
  logic [SH_W-1:0] amt;
  logic            active;
  logic [W-1:0]    shifted;
  logic            cf_d, of_d, fv_d;

  shrot_decode #(.CNT_W(CNT_W), .SH_W(SH_W)) u_dec (
    .op(op_i), .count(count_i), .ctl(ctl), .amt(amt), .active(active)
  );

  shrot_barrel #(.W(W), .SH_W(SH_W)) u_bar (
    .din(operand_i), .amt(amt), .dir_left(ctl.dir_left),
    .rotate(ctl.rotate), .arith(ctl.arith), .dout(shifted)
  );

  shrot_flags #(.W(W), .SH_W(SH_W)) u_flg (
    .din(operand_i), .dout(shifted), .amt(amt), .dir_left(ctl.dir_left),
    .rotate(ctl.rotate), .active(active),
    .carry(cf_d), .overflow(of_d), .valid(fv_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o      <= '0;
      carry_o       <= 1'b0;
      overflow_o    <= 1'b0;
      flags_valid_o <= 1'b0;
    end else begin
      result_o      <= shifted;
      carry_o       <= cf_d;
      overflow_o    <= of_d;
      flags_valid_o <= fv_d;
    end
  end
endmodule

// File: rtl/shrot_checker.sv
module shrot_checker #(
  parameter int W     = 64,
  parameter int CNT_W = 8,
  parameter int SH_W  = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     operand_i,
  input logic [CNT_W-1:0] count_i,
  input logic [2:0]       op_i,
  input logic [W-1:0]     result_o,
  input logic             carry_o,
  input logic             overflow_o,
  input logic             flags_valid_o
);
  logic primed;
  always_ff @(posedge clk) primed <= rst ? 1'b0 : 1'b1;

  assert_zero_count_R8: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(count_i[SH_W-1:0]) == '0) |-> (!flags_valid_o && result_o == $past(operand_i)));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(count_i[SH_W-1:0]) > SH_W'(1)) |-> !overflow_o);

  assert_rotate_keeps_bits_R4: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(op_i) == 3'b100 || $past(op_i) == 3'b101)
      |-> ($countones(result_o) == $countones($past(operand_i))));

  assert_sign_fill_R3: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(op_i) == 3'b011) |-> (result_o[W-1] == $past(operand_i[W-1])));

  assert_unused_op_R11: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(op_i) == 3'b110 || $past(op_i) == 3'b111)
      |-> (!flags_valid_o && !carry_o && result_o == $past(operand_i)));

  assert_reset_clear_R12: assert property (@(posedge clk)
    $past(rst) |-> (result_o == '0 && !carry_o && !flags_valid_o));
endmodule

bind shrot_unit shrot_checker #(.W(W), .CNT_W(CNT_W), .SH_W(SH_W)) u_chk (.*);

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] operand_i = '0;
  logic [7:0]  count_i = '0;
  logic [2:0]  op_i = '0;
  logic [63:0] result_o;
  logic        carry_o, overflow_o, flags_valid_o;

  int checks = 0;
  int errors = 0;
  logic        pend = 1'b0;
  logic [63:0] e_res;
  logic        e_cf, e_of, e_fv;
  string       tag_res, tag_cf, tag_of, tag_fv;
  logic [63:0] rng = 64'h1234_5678_9abc_def1;

  always #2 clk = ~clk;

  shrot_unit u0 (.*);

  task automatic chk(string what, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural model: single-bit steps, one at a time
  task automatic model(input logic [2:0] op, input logic [63:0] a, input logic [7:0] c);
    int n;
    logic [63:0] v;
    logic cf, b;
    n = int'(c[5:0]);
    v = a; cf = 1'b0;
    if (op > 3'd5) n = 0;
    for (int i = 0; i < n; i++) begin
      case (op)
        3'd0, 3'd1: begin cf = v[63]; v = v << 1; end
        3'd2:       begin cf = v[0];  v = v >> 1; end
        3'd3:       begin cf = v[0];  v = {v[63], v[63:1]}; end
        3'd4:       begin b = v[63]; v = {v[62:0], b}; cf = b; end
        default:    begin b = v[0];  v = {b, v[63:1]}; cf = b; end
      endcase
    end
    e_res = v;
    e_fv  = (n != 0);
    e_cf  = (n != 0) & cf;
    e_of  = (n == 1) & (v[63] ^ a[63]);
    if (op > 3'd5)            tag_res = "R11";
    else if (c[7:6] != 2'b00) tag_res = "R7";
    else if (n == 0)          tag_res = "R8";
    else if (op <= 3'd1)      tag_res = "R1";
    else if (op == 3'd2)      tag_res = "R2";
    else if (op == 3'd3)      tag_res = "R3";
    else                      tag_res = "R4";
    tag_cf = (n == 0) ? "R8" : (op >= 3'd4 ? "R6" : "R5");
    tag_of = (n == 1) ? "R9" : "R10";
    tag_fv = (op > 3'd5) ? "R11" : "R8";
  endtask

  // drive at negedge; outputs of previous drive are checked first
  task automatic step(input logic r, input logic [2:0] op, input logic [63:0] a, input logic [7:0] c);
    @(negedge clk);
    if (pend) begin
      chk("result", tag_res, result_o, e_res);
      chk("carry", tag_cf, 64'(carry_o), 64'(e_cf));
      chk("overflow", tag_of, 64'(overflow_o), 64'(e_of));
      chk("valid", tag_fv, 64'(flags_valid_o), 64'(e_fv));
    end
    rst = r; op_i = op; operand_i = a; count_i = c;
    if (r) begin
      e_res = '0; e_cf = 0; e_of = 0; e_fv = 0;
      tag_res = "R12"; tag_cf = "R12"; tag_of = "R12"; tag_fv = "R12";
    end else model(op, a, c);
    pend = 1'b1;
  endtask

  function automatic logic [63:0] nxt(logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13); t = t ^ (t >> 7); t = t ^ (t << 17);
    return t;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    step(1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd5);   // R12 reset clears outputs
    step(1, 3'd0, 64'h0, 8'd0);
    // every count for every code on two operand patterns (R1..R6, R8..R11)
    for (int op = 0; op < 8; op++)
      for (int c = 0; c < 64; c++) begin
        step(0, 3'(op), 64'h8000_0000_0000_0001 ^ (64'h1 << c), 8'(c));
        step(0, 3'(op), 64'hC3A5_0F96_7E81_2B4D, 8'(c));
      end
    // R9: count one, sign flips or not
    step(0, 3'd0, 64'h4000_0000_0000_0000, 8'd1);
    step(0, 3'd2, 64'h8000_0000_0000_0000, 8'd1);
    step(0, 3'd3, 64'h8000_0000_0000_0000, 8'd1);
    step(0, 3'd4, 64'h4000_0000_0000_0000, 8'd1);
    step(0, 3'd5, 64'h0000_0000_0000_0001, 8'd1);
    // R3: negative operand, maximum count
    step(0, 3'd3, 64'h8000_0000_0000_0000, 8'd63);
    // R7: upper count bits ignored
    step(0, 3'd0, 64'h0123_4567_89AB_CDEF, 8'd64);
    step(0, 3'd2, 64'h0123_4567_89AB_CDEF, 8'd193);
    step(0, 3'd4, 64'h0123_4567_89AB_CDEF, 8'd132);
    // mid-run reset (R12)
    step(1, 3'd4, 64'hDEAD_BEEF_0000_0001, 8'd3);
    // pseudo-random sweep
    for (int i = 0; i < 3000; i++) begin
      rng = nxt(rng);
      step(0, rng[2:0], nxt(rng ^ 64'h5555), rng[15:8]);
    end
    step(0, 3'd0, 64'h0, 8'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule